// File: doc/BRIEF.md
# Posted Write Delivery Retry Engine

This block sequences the delivery of one buffered posted write onto a target bus. By the time it starts, the initiator has already been released. A transaction is loaded from the write buffer as a start address, a bus command and a DWORD count. The engine then requests a bus attempt and keeps that request up until it finishes with the transaction. Nothing can be reported back to the original initiator, so every outcome shows up in one of three places: a completion pulse, a flush pulse that tells the buffer to discard the remaining data, or a set of status and system-error outputs.

Each attempt ends with a termination code and the number of DWORDs that were actually moved. The engine uses these to choose what to do next:

- A retry repeats the attempt unchanged.
- A disconnect, or a normal end that leaves data behind, restarts at the first undelivered DWORD.
- A memory-write-and-invalidate that was only partly delivered continues as a plain memory write, because the rest is no longer a whole cache line.
- A target abort ends the transaction.

The number of attempts per transaction is bounded by a parameterised limit. Running out of attempts also ends the transaction, with an error that can be masked.

Top module: `pwe_retry_engine`

## Requirements
- R1: After reset `att_req`, `done`, `flush`, `serr_req`, `rx_tabort` and `sig_serr` are 0. When `ld_valid` is high with a nonzero `ld_dwords` while no attempt is outstanding, the next cycle shows `att_req`=1 with `att_addr`, `att_cmd` and `att_dwords` equal to the loaded values. A load with `ld_dwords`=0 is ignored.
- R2: Termination codes are 00 normal, 01 retry, 10 disconnect and 11 abort. On a retry that does not exhaust the limit, the next attempt keeps the same address, command and DWORD count.
- R3: On a normal or disconnect termination that leaves data, the next attempt address is the old address plus 4 times the DWORDs moved, and the remaining count drops by the DWORDs moved. A moved count larger than the remainder is treated as the remainder.
- R4: If the command is memory-write-and-invalidate (1111) and at least one DWORD was moved before a normal or disconnect termination that leaves data, the next attempt uses memory write (0111). If zero DWORDs were moved, the command is kept.
- R5: When a normal or disconnect termination leaves zero DWORDs, `done` pulses for one cycle, `att_req` drops, and there is no flush and no system error.
- R6: On an abort, `rx_tabort` is set and stays set, `flush` pulses and `att_req` drops. `serr_req` pulses only if `serr_en` is 1, and `sig_serr` is set only when `serr_req` pulses.
- R7: Each transaction gets at most 2^ATTEMPT_W attempts. If that many attempts have been made and another would be needed, `flush` pulses and `att_req` drops. `serr_req` pulses, and `sig_serr` is set, only if `serr_en`=1 and `nodeliver_mask`=0.
- R8: `ld_valid` is ignored while an attempt is outstanding. The attempt count starts afresh with each accepted load.
- R9: `term_valid` is ignored while no attempt is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Buffer presents a new posted transaction |
| ld_addr | input | ADDR_W | Start byte address |
| ld_cmd | input | 4 | Bus write command |
| ld_dwords | input | CNT_W | DWORDs held for the transaction |
| term_valid | input | 1 | Current attempt has ended |
| term_code | input | 2 | Termination type of the attempt |
| term_xfer | input | CNT_W | DWORDs moved in the attempt |
| serr_en | input | 1 | System error reporting enable |
| nodeliver_mask | input | 1 | Suppresses the system error on attempt exhaustion |
| att_req | output | 1 | An attempt is requested |
| att_addr | output | ADDR_W | Address for the attempt |
| att_cmd | output | 4 | Command for the attempt |
| att_dwords | output | CNT_W | DWORDs still to deliver |
| done | output | 1 | One-cycle pulse: transaction delivered |
| flush | output | 1 | One-cycle pulse: discard buffered data |
| serr_req | output | 1 | One-cycle system error request |
| rx_tabort | output | 1 | Sticky: target abort received |
| sig_serr | output | 1 | Sticky: system error signalled |

## Verification
Some properties are checked on every cycle. A retry holds the request fields steady. A disconnect shortens the remainder and demotes a partly delivered invalidate write. An abort flushes and sets its sticky bit. A load or a termination that arrives at the wrong time leaves the state untouched. The counter can never advance past its limit, and no system error request appears without the signalled bit.

Other behaviours only show up across whole scenarios. These are the exact attempt number at which exhaustion happens, how the masking inputs combine, and the cumulative addresses after a chain of mixed disconnects, retries and oversized moved counts. The bench compares those scenarios against its own model.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

    typedef enum logic [1:0] {
        TERM_NORMAL = 2'b00,
        TERM_RETRY  = 2'b01,
        TERM_DISC   = 2'b10,
        TERM_ABORT  = 2'b11
    } term_e;

    typedef enum logic [1:0] {
        ACT_AGAIN = 2'b00,
        ACT_DONE  = 2'b01,
        ACT_ABORT = 2'b10
    } act_e;

    localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
    localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

    // a partly delivered invalidate write can no longer cover whole lines
    function automatic logic [3:0] restart_cmd(input logic [3:0] cmd, input logic moved_any);
        if (moved_any && cmd == CMD_MEM_WR_INV)
            return CMD_MEM_WR;
        return cmd;
    endfunction

endpackage

// File: rtl/pwe_restart_calc.sv
module pwe_restart_calc
    import pwe_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [3:0]        cur_cmd,
    input  logic [CNT_W-1:0]  cur_rem,
    input  term_e             term,
    input  logic [CNT_W-1:0]  xfer,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [3:0]        nxt_cmd,
    output logic [CNT_W-1:0]  nxt_rem,
    output act_e              act
);
    localparam int PAD_W = ADDR_W - CNT_W;

    logic [CNT_W-1:0]  moved;
    logic [ADDR_W-1:0] byte_step;

    always_comb begin
        moved     = (xfer > cur_rem) ? cur_rem : xfer;
        byte_step = {{PAD_W{1'b0}}, moved} << 2;
        nxt_addr  = cur_addr;
        nxt_cmd   = cur_cmd;
        nxt_rem   = cur_rem;
        act       = ACT_AGAIN;
        unique case (term)
            TERM_RETRY: act = ACT_AGAIN;
            TERM_NORMAL, TERM_DISC: begin
                nxt_rem  = cur_rem - moved;
                nxt_addr = cur_addr + byte_step;
                nxt_cmd  = restart_cmd(cur_cmd, moved != '0);
                act      = (nxt_rem == '0) ? ACT_DONE : ACT_AGAIN;
            end
            TERM_ABORT: act = ACT_ABORT;
            default:    act = ACT_AGAIN;
        endcase
    end
endmodule

// File: rtl/pwe_attempt_ctr.sv
module pwe_attempt_ctr #(
    parameter int ATTEMPT_W = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic advance,
    output logic last
);
    localparam int CW = ATTEMPT_W + 1;
    localparam logic [CW-1:0] LIMIT = {1'b1, {ATTEMPT_W{1'b0}}};

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (restart)
            cnt <= {{(CW-1){1'b0}}, 1'b1};
        else if (advance)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LIMIT);

    AST_NO_ADVANCE_PAST_LIMIT: assert property (@(posedge clk) disable iff (rst)
        advance |-> !last); // R7
endmodule

// File: rtl/pwe_err_report.sv
module pwe_err_report (
    input  logic clk,
    input  logic rst,
    input  logic abort_ev,
    input  logic exhaust_ev,
    input  logic serr_en,
    input  logic nodeliver_mask,
    output logic serr_req,
    output logic rx_tabort,
    output logic sig_serr
);
    logic raise;

    always_comb
        raise = serr_en && (abort_ev || (exhaust_ev && !nodeliver_mask));

    always_ff @(posedge clk) begin
        if (rst) begin
            serr_req  <= 1'b0;
            rx_tabort <= 1'b0;
            sig_serr  <= 1'b0;
        end else begin
            serr_req <= raise;
            if (abort_ev) rx_tabort <= 1'b1;
            if (raise)    sig_serr  <= 1'b1;
        end
    end

    AST_SERR_MARKED: assert property (@(posedge clk) disable iff (rst)
        serr_req |-> sig_serr); // R6
    AST_TABORT_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(rx_tabort) |-> rx_tabort); // R6
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (exhaust_ev && nodeliver_mask && !abort_ev) |=> !serr_req); // R7
endmodule

// File: rtl/pwe_retry_engine.sv
module pwe_retry_engine
    import pwe_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 10,
    parameter int ATTEMPT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [3:0]        ld_cmd,
    input  logic [CNT_W-1:0]  ld_dwords,
    input  logic              term_valid,
    input  logic [1:0]        term_code,
    input  logic [CNT_W-1:0]  term_xfer,
    input  logic              serr_en,
    input  logic              nodeliver_mask,
    output logic              att_req,
    output logic [ADDR_W-1:0] att_addr,
    output logic [3:0]        att_cmd,
    output logic [CNT_W-1:0]  att_dwords,
    output logic              done,
    output logic              flush,
    output logic              serr_req,
    output logic              rx_tabort,
    output logic              sig_serr
);
    logic [ADDR_W-1:0] nxt_addr;
    logic [3:0]        nxt_cmd;
    logic [CNT_W-1:0]  nxt_rem;
    act_e              act;
    logic              take, accept, ctr_last, again, exhaust, abort_ev;

    pwe_restart_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_calc (
        .cur_addr (att_addr),
        .cur_cmd  (att_cmd),
        .cur_rem  (att_dwords),
        .term     (term_e'(term_code)),
        .xfer     (term_xfer),
        .nxt_addr (nxt_addr),
        .nxt_cmd  (nxt_cmd),
        .nxt_rem  (nxt_rem),
        .act      (act)
    );

    always_comb begin
        take     = att_req && term_valid;
        accept   = !att_req && ld_valid && (ld_dwords != '0);
        again    = take && (act == ACT_AGAIN);
        exhaust  = again && ctr_last;
        abort_ev = take && (act == ACT_ABORT);
    end

    pwe_attempt_ctr #(.ATTEMPT_W(ATTEMPT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .advance (again && !ctr_last),
        .last    (ctr_last)
    );

    pwe_err_report u_err (
        .clk            (clk),
        .rst            (rst),
        .abort_ev       (abort_ev),
        .exhaust_ev     (exhaust),
        .serr_en        (serr_en),
        .nodeliver_mask (nodeliver_mask),
        .serr_req       (serr_req),
        .rx_tabort      (rx_tabort),
        .sig_serr       (sig_serr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            att_req    <= 1'b0;
            att_addr   <= '0;
            att_cmd    <= '0;
            att_dwords <= '0;
            done       <= 1'b0;
            flush      <= 1'b0;
        end else begin
            done  <= 1'b0;
            flush <= 1'b0;
            if (accept) begin
                att_req    <= 1'b1;
                att_addr   <= ld_addr;
                att_cmd    <= ld_cmd;
                att_dwords <= ld_dwords;
            end else if (take) begin
                unique case (act)
                    ACT_AGAIN: begin
                        if (ctr_last) begin
                            att_req <= 1'b0;
                            flush   <= 1'b1;
                        end else begin
                            att_addr   <= nxt_addr;
                            att_cmd    <= nxt_cmd;
                            att_dwords <= nxt_rem;
                        end
                    end
                    ACT_DONE: begin
                        att_req    <= 1'b0;
                        att_dwords <= '0;
                        done       <= 1'b1;
                    end
                    default: begin
                        att_req <= 1'b0;
                        flush   <= 1'b1;
                    end
                endcase
            end
        end
    end

    AST_RETRY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (take && term_code == 2'b01 && !ctr_last) |=>
        (att_req && $stable(att_addr) && $stable(att_cmd) && $stable(att_dwords))); // R2
    AST_DISC_SHRINK: assert property (@(posedge clk) disable iff (rst)
        (take && term_code == 2'b10 && term_xfer != '0 && term_xfer < att_dwords && !ctr_last) |=>
        (att_req && att_dwords == $past(att_dwords) - $past(term_xfer))); // R3
    AST_MWI_DEMOTE: assert property (@(posedge clk) disable iff (rst)
        (take && term_code == 2'b10 && att_cmd == 4'b1111 && term_xfer != '0
         && term_xfer < att_dwords && !ctr_last) |=> (att_cmd == 4'b0111)); // R4
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done |-> (!flush && !att_req && !serr_req)); // R5
    AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (take && term_code == 2'b11) |=> (flush && rx_tabort && !att_req)); // R6
    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (att_req && ld_valid && !term_valid) |=>
        (att_req && $stable(att_addr) && $stable(att_dwords))); // R8
    AST_IDLE_TERM: assert property (@(posedge clk) disable iff (rst)
        (!att_req && term_valid && !ld_valid) |=> (!att_req && !done && !flush)); // R9
endmodule

// File: tb/pwe_retry_engine_test.sv
`timescale 1ns/1ps
module pwe_retry_engine_test;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int ATW = 3;
    localparam int LIMIT = 1 << ATW;
    localparam logic [3:0] MW = 4'b0111;
    localparam logic [3:0] MWI = 4'b1111;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [3:0] ld_cmd = '0;
    logic [CW-1:0] ld_dwords = '0;
    logic term_valid = 1'b0;
    logic [1:0] term_code = '0;
    logic [CW-1:0] term_xfer = '0;
    logic serr_en = 1'b0;
    logic nodeliver_mask = 1'b0;
    logic att_req, done, flush, serr_req, rx_tabort, sig_serr;
    logic [AW-1:0] att_addr;
    logic [3:0] att_cmd;
    logic [CW-1:0] att_dwords;

    int n_checks = 0;
    int n_errors = 0;

    // bench model state
    logic [AW-1:0] m_addr;
    logic [3:0] m_cmd;
    int m_rem, m_cnt;
    logic m_busy, m_tabort, m_sig;

    always #4 clk = ~clk;

    pwe_retry_engine #(.ADDR_W(AW), .CNT_W(CW), .ATTEMPT_W(ATW)) uut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_cmd(ld_cmd),
        .ld_dwords(ld_dwords), .term_valid(term_valid), .term_code(term_code),
        .term_xfer(term_xfer), .serr_en(serr_en), .nodeliver_mask(nodeliver_mask),
        .att_req(att_req), .att_addr(att_addr), .att_cmd(att_cmd), .att_dwords(att_dwords),
        .done(done), .flush(flush), .serr_req(serr_req), .rx_tabort(rx_tabort),
        .sig_serr(sig_serr));

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int clamp_moved(input int xfer, input int rem);
        return (xfer > rem) ? rem : xfer;
    endfunction

    function automatic logic [3:0] exp_cmd(input logic [3:0] cmd, input int moved);
        return (moved != 0 && cmd == MWI) ? MW : cmd;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [3:0] c, input int n);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_cmd = c; ld_dwords = CW'(n);
        @(negedge clk);
        ld_valid = 1'b0;
        if (n != 0) begin
            m_addr = a; m_cmd = c; m_rem = n; m_cnt = 1; m_busy = 1'b1;
        end
        chk("R1", "att_req after load", att_req, m_busy);
        if (m_busy) begin
            chk("R1", "att_addr", att_addr, m_addr);
            chk("R1", "att_cmd", att_cmd, m_cmd);
            chk("R1", "att_dwords", att_dwords, m_rem);
        end
    endtask

    // one attempt: verify request fields, apply termination, verify outcome
    task automatic attempt(input logic [1:0] code, input int xfer, input string req);
        logic e_done, e_flush, e_serr;
        int mv;
        chk(req, "att_req before term", att_req, 1'b1);
        chk(req, "att_addr", att_addr, m_addr);
        chk(req, "att_cmd", att_cmd, m_cmd);
        chk(req, "att_dwords", att_dwords, m_rem);
        term_valid = 1'b1; term_code = code; term_xfer = CW'(xfer);
        @(negedge clk);
        term_valid = 1'b0;
        e_done = 0; e_flush = 0; e_serr = 0;
        case (code)
            2'b11: begin
                e_flush = 1; e_serr = serr_en; m_tabort = 1; m_busy = 0;
            end
            2'b01: begin
                if (m_cnt == LIMIT) begin
                    e_flush = 1; e_serr = serr_en && !nodeliver_mask; m_busy = 0;
                end else m_cnt++;
            end
            default: begin
                mv = clamp_moved(xfer, m_rem);
                if (m_rem - mv == 0) begin
                    e_done = 1; m_busy = 0;
                end else if (m_cnt == LIMIT) begin
                    e_flush = 1; e_serr = serr_en && !nodeliver_mask; m_busy = 0;
                end else begin
                    m_cnt++;
                    m_rem = m_rem - mv;
                    m_addr = m_addr + AW'(4 * mv);
                    m_cmd = exp_cmd(m_cmd, mv);
                end
            end
        endcase
        if (e_serr) m_sig = 1;
        chk(req, "done", done, e_done);
        chk(req, "flush", flush, e_flush);
        chk(req, "serr_req", serr_req, e_serr);
        chk(req, "att_req after term", att_req, m_busy);
        chk(req, "rx_tabort", rx_tabort, m_tabort);
        chk(req, "sig_serr", sig_serr, m_sig);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        m_busy = 0; m_tabort = 0; m_sig = 0; m_cnt = 0; m_rem = 0;
        m_addr = '0; m_cmd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state R1
        chk("R1", "reset att_req", att_req, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset flush", flush, 0);
        chk("R1", "reset serr_req", serr_req, 0);
        chk("R1", "reset rx_tabort", rx_tabort, 0);
        chk("R1", "reset sig_serr", sig_serr, 0);

        // zero-length load ignored R1
        load(32'h100, MW, 0);

        // termination while idle ignored R9
        term_valid = 1'b1; term_code = 2'b00; term_xfer = 8'd4;
        @(negedge clk);
        term_valid = 1'b0;
        chk("R9", "idle term att_req", att_req, 0);
        chk("R9", "idle term done", done, 0);
        chk("R9", "idle term flush", flush, 0);

        // MWI: zero moved keeps command, partial demotes R4, retry holds R2
        serr_en = 1'b1; nodeliver_mask = 1'b0;
        load(32'h1000, MWI, 6);
        attempt(2'b10, 0, "R4");
        attempt(2'b01, 0, "R2");
        chk("R4", "cmd kept on zero moved", att_cmd, MWI);
        // load while busy ignored R8
        ld_valid = 1'b1; ld_addr = 32'hdead0000; ld_cmd = MW; ld_dwords = 8'd3;
        @(negedge clk);
        ld_valid = 1'b0;
        chk("R8", "busy load addr", att_addr, m_addr);
        chk("R8", "busy load dwords", att_dwords, m_rem);
        attempt(2'b10, 2, "R4");
        chk("R4", "cmd demoted", att_cmd, MW);
        attempt(2'b00, 1, "R3");
        attempt(2'b10, 50, "R5"); // oversized moved count clamps R3

        // exhaustion with mask set: no serr R7
        nodeliver_mask = 1'b1;
        load(32'h2000, MW, 4);
        for (int i = 0; i < LIMIT; i++) attempt(2'b01, 0, "R7");
        chk("R7", "masked sig_serr", sig_serr, 0);

        // exhaustion unmasked via disconnects, counter restarted R8
        nodeliver_mask = 1'b0;
        load(32'h3000, MWI, 20);
        for (int i = 0; i < LIMIT; i++) attempt(2'b10, 1, "R7");
        chk("R7", "unmasked sig_serr", sig_serr, 1);

        // abort without serr enable R6
        serr_en = 1'b0;
        load(32'h4000, MW, 3);
        attempt(2'b11, 1, "R6");

        // constrained random mix
        for (int t = 0; t < 60; t++) begin
            int n, r;
            logic [AW-1:0] a;
            serr_en = 1'($urandom_range(0, 1));
            nodeliver_mask = 1'($urandom_range(0, 1));
            n = $urandom_range(1, 24);
            a = {$urandom_range(0, 32'h3fff_ffff), 2'b00};
            load(a, ($urandom_range(0, 1) != 0) ? MWI : MW, n);
            while (m_busy) begin
                logic [1:0] code;
                r = $urandom_range(0, 99);
                if (r < 35) code = 2'b01;
                else if (r < 75) code = 2'b10;
                else if (r < 97) code = 2'b00;
                else code = 2'b11;
                attempt(code, $urandom_range(0, m_rem + 2),
                        code == 2'b01 ? "R2" : (code == 2'b11 ? "R6" : "R3"));
            end
        end
        finish_run();
    end
endmodule